// File: doc/BRIEF.md
# Handshaked Control Register Port Target

This block is the register side of a narrow parallel control port. A requester reaches a small bank of 16-bit control registers through one shared 16-bit input bus and four strobes: capture-address, capture-data, write and read. A register write takes three stages. The first latches an offset, the second latches a value, and the third commits that value to the offset. A register read takes two stages: latch an offset, then read. Every stage is a complete four-phase request/acknowledge exchange. The requester raises one strobe and waits for the acknowledge. It then drops the strobe and waits for the acknowledge to fall before it starts the next stage.

The offset space of the port runs from 0 to 0x201F. Only the lowest `NUM_REGS` offsets are backed by storage. Writes to any other offset are dropped and reads of it return zero, but the handshake still completes. The acknowledge is delayed by a parameterised latency of 1 to 8 cycles, so a requester's timeout path can be tested. A request that raises more than one strobe at once is refused: nothing changes and no acknowledge is given.

The control is a three-state machine.
- `S_IDLE` waits for exactly one strobe (transition `T_START`). Several strobes at once keep it in `S_IDLE` (transition `T_REFUSE`).
- `S_DELAY` counts out the latency (`T_COUNT`) and then moves on to `S_ACK` (`T_GRANT`). With a latency of 1, `T_START` goes straight to `S_ACK`.
- `S_ACK` holds the acknowledge until the strobe that opened the exchange is low, then returns to `S_IDLE` (`T_RELEASE`).

The stage's action takes effect on the clock edge of `T_START`.

Top module: `cr_port_target`

## Requirements
- R1: A capture-address stage latches `din` as the target offset. Later reads and writes use that offset.
- R2: A capture-data stage latches `din` as the pending value and leaves every register unchanged.
- R3: A write stage copies the pending value into the register at the latched offset.
- R4: While the acknowledge of a read stage is high, `dout` carries the addressed register's value. At all other times `dout` is zero.
- R5: Take the clock edge that first samples a single strobe in the idle state as edge 0. `ack` goes high after edge `ACK_LAT-1`, which is `ACK_LAT` falling-edge samples after the strobe was driven.
- R6: `ack` stays high while the opening strobe is held. It is low one cycle after that strobe drops.
- R7: If the latched offset is `NUM_REGS` or above (this includes offsets above 0x201F), a write changes nothing and a read returns 0. Both still complete the handshake.
- R8: If two or more strobes are high together in the idle state, no latch or register changes and `ack` stays low.
- R9: After reset, register i holds `RST_SEED ^ i`, the offset latch is zero, and `ack` and `dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Shared bus for offsets and write values |
| cap_addr_i | input | 1 | Capture-address strobe |
| cap_data_i | input | 1 | Capture-data strobe |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| dout | output | 16 | Read data, valid while `ack` is high in a read stage |
| ack | output | 1 | Handshake acknowledge |

## Verification
A wrong offset or pending-value latch does not show at once. It appears only at the next read, as a value that differs from what a write sent earlier to the same offset. For that reason every random write is later read back and compared against a register model. A stuck or miscounted state machine shows in the same stage: the acknowledge comes at the wrong falling-edge sample, does not hold while the strobe is held, or stays high a cycle after the strobe drops. A refused multi-strobe request is checked in two ways. The acknowledge must stay low, and a later read must show that the offset latch did not move.

// File: rtl/cr_port_pkg.sv
package cr_port_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_ACK   = 2'd2
    } hs_state_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_CAP_ADDR = 3'd1,
        OP_CAP_DATA = 3'd2,
        OP_WRITE    = 3'd3,
        OP_READ     = 3'd4
    } cr_op_e;

    localparam int unsigned STROBE_N = 4;

endpackage

// File: rtl/cr_strobe_decode.sv
module cr_strobe_decode
    import cr_port_pkg::*;
(
    input  logic [STROBE_N-1:0] strobes,
    output cr_op_e              op,
    output logic                single,
    output logic                none
);
    // strobes bit order: 0 capture-address, 1 capture-data, 2 write, 3 read
    always_comb begin
        single = 1'b1;
        none   = 1'b0;
        op     = OP_NONE;
        unique case (strobes)
            4'b0000: begin none = 1'b1; single = 1'b0; end
            4'b0001: op = OP_CAP_ADDR;
            4'b0010: op = OP_CAP_DATA;
            4'b0100: op = OP_WRITE;
            4'b1000: op = OP_READ;
            default: single = 1'b0;
        endcase
    end
endmodule

// File: rtl/cr_handshake_fsm.sv
module cr_handshake_fsm
    import cr_port_pkg::*;
#(
    parameter int unsigned ACK_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STROBE_N-1:0] strobes,
    input  cr_op_e              op_i,
    input  logic                single_i,
    output hs_state_e           state,
    output cr_op_e              active_op,
    output logic                fire,
    output logic                ack
);
    localparam int unsigned CNT_W = $clog2(ACK_LAT + 1);

    hs_state_e         nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              held;

    // level of the strobe that opened the current exchange
    always_comb begin
        held = 1'b0;
        unique case (active_op)
            OP_CAP_ADDR: held = strobes[0];
            OP_CAP_DATA: held = strobes[1];
            OP_WRITE:    held = strobes[2];
            OP_READ:     held = strobes[3];
            default:     held = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (single_i) begin
                    // T_START, or T_REFUSE when not single
                    nxt = (ACK_LAT <= 1) ? S_ACK : S_DELAY;
                end
            end
            S_DELAY: begin
                if (cnt_q <= CNT_W'(1)) nxt = S_ACK; // T_GRANT
            end
            S_ACK: begin
                if (!held) nxt = S_IDLE;             // T_RELEASE
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt_q     <= '0;
            active_op <= OP_NONE;
        end else begin
            state <= nxt;
            if (state == S_IDLE && single_i) begin
                cnt_q     <= CNT_W'(ACK_LAT - 1);
                active_op <= op_i;
            end else if (state == S_DELAY) begin
                cnt_q <= cnt_q - CNT_W'(1);          // T_COUNT
            end else if (state == S_ACK && !held) begin
                active_op <= OP_NONE;
            end
        end
    end

    // outputs
    always_comb begin
        fire = (state == S_IDLE) && single_i;
        ack  = (state == S_ACK);
    end
endmodule

// File: rtl/cr_reg_bank.sv
module cr_reg_bank #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter logic [DATA_W-1:0] RST_SEED = 16'h5A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        in_range = ({16'd0, addr} < 32'(NUM_REGS));
        idx      = addr[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= RST_SEED ^ DATA_W'(g);
            end else if (we && in_range && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) rdata = regs[idx];
    end
endmodule

// File: rtl/cr_port_target.sv
module cr_port_target
    import cr_port_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned ACK_LAT  = 2,
    parameter logic [15:0] RST_SEED = 16'h5A00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] din,
    input  logic        cap_addr_i,
    input  logic        cap_data_i,
    input  logic        wr_i,
    input  logic        rd_i,
    output logic [15:0] dout,
    output logic        ack
);
    localparam int unsigned DATA_W = 16;

    logic [STROBE_N-1:0] strobes;
    cr_op_e              dec_op;
    cr_op_e              active_op;
    logic                single;
    logic                none;
    logic                fire;
    hs_state_e           st_w;
    logic [DATA_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   rd_q;
    logic [DATA_W-1:0]   bank_rdata;
    logic                bank_we;

    assign strobes = {rd_i, wr_i, cap_data_i, cap_addr_i};

    cr_strobe_decode u_dec (
        .strobes (strobes),
        .op      (dec_op),
        .single  (single),
        .none    (none)
    );

    cr_handshake_fsm #(.ACK_LAT(ACK_LAT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobes   (strobes),
        .op_i      (dec_op),
        .single_i  (single),
        .state     (st_w),
        .active_op (active_op),
        .fire      (fire),
        .ack       (ack)
    );

    assign bank_we = fire && (dec_op == OP_WRITE);

    cr_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (DATA_W),
        .RST_SEED (RST_SEED)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            rd_q   <= '0;
        end else if (fire) begin
            unique case (dec_op)
                OP_CAP_ADDR: addr_q <= din;
                OP_CAP_DATA: data_q <= din;
                OP_READ:     rd_q   <= bank_rdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        dout = '0;
        if (ack && active_op == OP_READ) dout = rd_q;
    end

    logic unused_ok;
    assign unused_ok = none;
endmodule

// File: rtl/cr_port_target_chk.sv
module cr_port_target_chk
    import cr_port_pkg::*;
#(
    parameter int unsigned ACK_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_addr_i,
    input  logic        cap_data_i,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic        ack,
    input  logic [15:0] dout,
    input  hs_state_e   st_w
);
    logic [3:0] s;
    logic [3:0] busy_cnt;

    assign s = {rd_i, wr_i, cap_data_i, cap_addr_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (st_w == S_IDLE)   busy_cnt <= '0;
        else if (busy_cnt != 4'hF) busy_cnt <= busy_cnt + 4'd1;
    end

    a_r4_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> dout == 16'h0);

    a_r5_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> busy_cnt == 4'(ACK_LAT - 1));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && s == 4'b0000) |=> !ack);

    a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == S_IDLE && $countones(s) > 1) |=> (st_w == S_IDLE && !ack));

    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_w inside {S_IDLE, S_DELAY, S_ACK});
endmodule

bind cr_port_target cr_port_target_chk #(.ACK_LAT(ACK_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_addr_i (cap_addr_i),
    .cap_data_i (cap_data_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .ack        (ack),
    .dout       (dout),
    .st_w       (st_w)
);

// File: tb/cr_port_target_tb.sv
`timescale 1ns/1ps
module cr_port_target_tb;
    localparam int unsigned NREG = 32;
    localparam int unsigned LAT  = 3;
    localparam logic [15:0] SEED = 16'hC3A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic        cap_addr_i = 1'b0, cap_data_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
    logic [15:0] dout;
    logic        ack;

    int total = 0;
    int fails = 0;
    logic [15:0] model [NREG];
    logic        hold_ok, fall_ok;

    always #2 clk = ~clk;

    cr_port_target #(.NUM_REGS(NREG), .ACK_LAT(LAT), .RST_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din),
        .cap_addr_i(cap_addr_i), .cap_data_i(cap_data_i), .wr_i(wr_i), .rd_i(rd_i),
        .dout(dout), .ack(ack)
    );

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        if (a < 16'(NREG)) return model[a[4:0]];
        return 16'h0;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_strobe(input int op, input logic v);
        case (op)
            0: cap_addr_i = v;
            1: cap_data_i = v;
            2: wr_i = v;
            default: rd_i = v;
        endcase
    endtask

    // one four-phase stage: op 0 cap-addr, 1 cap-data, 2 write, 3 read
    task automatic stage(input int op, input logic [15:0] v,
                         output logic [15:0] rd, output int lat);
        @(negedge clk);
        din = v;
        set_strobe(op, 1'b1);
        lat = 0;
        while (!ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = dout;
        @(negedge clk);
        hold_ok = ack;
        set_strobe(op, 1'b0);
        @(negedge clk);
        fall_ok = !ack;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] v, input bit check_hs);
        logic [15:0] r; int l;
        stage(0, a, r, l);
        if (check_hs) begin
            chk("R5 ack latency", 16'(l), 16'(LAT));
            chk("R6 ack held", 16'(hold_ok), 16'd1);
            chk("R6 ack released", 16'(fall_ok), 16'd1);
        end
        stage(1, v, r, l);
        stage(2, 16'h0, r, l);
        if (check_hs) chk("R4 dout zero on write ack", r, 16'h0);
        if (a < 16'(NREG)) model[a[4:0]] = v;
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        logic [15:0] r; int l;
        stage(0, a, r, l);
        stage(3, 16'h0, r, l);
        chk(req, r, exp_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] r; int l;
        void'($urandom(32'd2468));
        for (int i = 0; i < NREG; i++) model[i] = SEED ^ 16'(i);
        repeat (3) @(negedge clk);
        chk("R9 ack at reset", 16'(ack), 16'd0);
        chk("R9 dout at reset", dout, 16'h0);
        rst_n = 1'b1;

        // R9: read with no address stage uses offset 0
        stage(3, 16'h0, r, l);
        chk("R9 reg0 default via zero offset latch", r, SEED);
        chk("R5 ack latency on read", 16'(l), 16'(LAT));
        chk("R4 dout zero after ack", dout, 16'h0);
        do_read(16'd17, "R9 reg17 default");

        // R1/R3: write then read back
        do_write(16'd5, 16'hBEEF, 1'b1);
        do_read(16'd5, "R1 R3 write readback");
        // R2: capture data alone changes nothing
        stage(0, 16'd6, r, l);
        stage(1, 16'h1234, r, l);
        stage(3, 16'h0, r, l);
        chk("R2 capture data leaves register", r, exp_read(16'd6));
        // pending value remains; write commits it
        stage(2, 16'h0, r, l);
        model[6] = 16'h1234;
        do_read(16'd6, "R3 commit pending value");

        // R7: out-of-range offsets
        do_write(16'd32, 16'hAAAA, 1'b1);
        do_read(16'd32, "R7 read beyond array");
        do_write(16'h2020, 16'h5555, 1'b0);
        do_read(16'hFFFF, "R7 read above offset space");
        do_read(16'd0, "R7 bank intact reg0");
        do_read(16'd31, "R7 last register");

        // R8: two strobes together are refused
        stage(0, 16'd5, r, l);
        @(negedge clk);
        din = 16'd9; cap_addr_i = 1'b1; rd_i = 1'b1;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (ack) seen = 1'b1;
            end
            chk("R8 no ack on conflict", 16'(seen), 16'd0);
        end
        cap_addr_i = 1'b0; rd_i = 1'b0;
        @(negedge clk);
        stage(3, 16'h0, r, l);
        chk("R8 offset latch unchanged", r, exp_read(16'd5));

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [15:0] a;
            a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % NREG);
            if ($urandom % 2 == 0) do_write(a, 16'($urandom), (n % 10) == 0);
            else do_read(a, "R1 R3 R7 random read");
        end
        for (int i = 0; i < NREG; i++) do_read(16'(i), "R3 final sweep");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule